// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter with Coherent Byte Reads

This block is a free-running 16-bit up-counter. Software reads and controls it over a small 8-bit register bus. The counter advances by one on each count-enable pulse. A 3-bit select field picks where those pulses come from:

- one of seven power-of-two divisions of the bus clock, or
- rising edges of an external clock pin. The pin is brought into the bus clock domain by a synchronizer before edges are detected.

A control register holds three fields:

- a stop bit, which freezes both the counter and the divider;
- a self-clearing clear bit, which zeroes both the counter and the divider;
- the source select.

Software reads the 16-bit count as two bytes. Reading the high byte freezes a copy of the low byte, so a following low-byte read returns a value that belongs with the high byte already taken. This holds even while the counter keeps running.

Top module: `prescaled_timer`

## Requirements
- R1: Writing control with bit 6 (clear) set zeroes the counter and the divider on the next clock edge. Counting then resumes upward from 0x0000.
- R2: The clear bit reads back as 0 at all times, drops by itself after one cycle, and leaves the stop bit and the select field as written.
- R3: A single control write with both bit 7 (stop) and bit 6 (clear) set leaves the counter held at 0x0000.
- R4: Select values 0 to 6 in control bits 2:0 advance the counter once every 2^sel bus clock cycles. The counter advances by at most one per cycle.
- R5: Select value 7 advances the counter once per rising edge on the external clock pin. The pin is synchronized, and its frequency must stay below half the bus clock.
- R6: A read of address 1 returns the counter's upper byte and stores the current lower byte. The next read of address 2 returns that stored byte.
- R7: Further address-1 reads do not refresh the stored byte until address 2 has been read.
- R8: An address-2 read with no pending address-1 read returns the live lower byte.
- R9: While the stop bit is set, the counter and the divider hold their values, and register reads work normally. When counting resumes, the divider phase continues from where it stopped.
- R10: After reset the counter is 0x0000 and control reads 0x00. Address 3 reads 0x00.
- R11: The counter wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 count high, 2 count low |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| ext_clk | input | 1 | External count clock, asynchronous |

## Verification
Some properties are checked on every cycle by the assertions:

- a pending clear always yields a zero count;
- a set stop bit with no clear keeps the count stable;
- the count never moves by more than one per cycle;
- the stored low byte stays frozen between an upper-byte read and the next lower-byte read;
- the clear bit never reads back as 1;
- an external-edge pulse never lasts more than one cycle.

Other behaviours need the bench's scenarios:

- the exact division ratio for each select value;
- the exact count taken from external edges;
- that the divider phase survives a stop;
- the wrap value;
- that the byte returned after an upper-byte read comes from the earlier cycle while the counter runs.

// File: rtl/tmr_pkg.sv
// Package: shared widths, register addresses and control field positions
// for the prescaled timer. Assumes the count is exactly two bus bytes wide.
package tmr_pkg;

    localparam int BUS_W   = 8;
    localparam int CNT_W   = 2 * BUS_W;
    localparam int SEL_W   = 3;
    localparam int ADDR_W  = 2;

    localparam int CTRL_STOP_BIT = 7;
    localparam int CTRL_CLR_BIT  = 6;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL   = 2'd0,
        ADR_CNT_HI = 2'd1,
        ADR_CNT_LO = 2'd2,
        ADR_SPARE  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/tmr_ext_sync.sv
// Module: tmr_ext_sync
// Brings an asynchronous external clock into the bus clock domain through a
// flop chain, then emits a one-cycle pulse for each rising edge it sees.
// Assumes the external clock runs below half the bus clock, so no edge is lost.
module tmr_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise_pulse
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the pin through the synchronizer and keep the previous stable level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], ext_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    // A rising edge is a stable high that was low one cycle before.
    always_comb begin
        rise_pulse = sync_q[STAGES-1] & ~last_q;
    end

    // R5: an edge pulse lasts exactly one cycle.
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Free-running divider of the bus clock. It selects one of 2^SEL_W-1
// power-of-two tick rates or an external edge pulse as the count enable.
// Assumes clr has priority over run, and that run gates every source.
module tmr_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_pulse,
    output logic             tick
);

    localparam int NSRC  = 1 << SEL_W;
    localparam int NDIV  = NSRC - 1;
    localparam int PRE_W = NDIV - 1;

    logic [PRE_W-1:0] pre_q;
    logic [NSRC-1:0]  src;

    // Advance the divider while running; clear or reset returns it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Tap k fires once every 2^k cycles, when the low k divider bits are all ones.
    generate
        for (genvar g = 0; g < NDIV; g++) begin : g_tap
            if (g == 0) begin : g_div1
                assign src[g] = 1'b1;
            end else begin : g_divn
                assign src[g] = &pre_q[g-1:0];
            end
        end
    endgenerate
    assign src[NSRC-1] = ext_pulse;

    // Pick the selected source and gate it with run.
    always_comb begin
        tick = run & src[sel];
    end

    // R9: a stopped divider keeps its phase.
    assert_pre_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(pre_q));

endmodule

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// Up-counter that adds one on each enable and wraps naturally at its width.
// Assumes clr takes priority over inc.
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);

    // Hold, increment, or return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            value <= '0;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end

    // R4/R11: the count moves by zero or one per cycle, and wraps modulo 2^W.
    assert_unit_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (value == $past(value)) || (value == $past(value) + 1'b1));

endmodule

// File: rtl/tmr_bus_regs.sv
// Module: tmr_bus_regs
// Register file. It holds the control register (stop, self-clearing clear,
// source select) and the low-byte snapshot used for coherent 16-bit reads.
// Assumes one-cycle strobes and combinational read data in the strobe cycle.
module tmr_bus_regs
    import tmr_pkg::*;
#(
    parameter int BW = 8,
    parameter int CW = 16,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [BW-1:0] wdata,
    input  logic [CW-1:0] count,
    output logic [BW-1:0] rdata,
    output logic          stop,
    output logic          clr_req,
    output logic [SW-1:0] sel
);

    logic          hi_rd, lo_rd, ctrl_wr;
    logic          held_q;
    logic [BW-1:0] snap_q;

    // Decode the strobes.
    always_comb begin
        hi_rd   = rd && (addr == ADR_CNT_HI);
        lo_rd   = rd && (addr == ADR_CNT_LO);
        ctrl_wr = wr && (addr == ADR_CTRL);
    end

    // Control register. The clear request lasts one cycle unless it is written again.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop    <= 1'b0;
            clr_req <= 1'b0;
            sel     <= '0;
        end else begin
            clr_req <= 1'b0;
            if (ctrl_wr) begin
                stop    <= wdata[CTRL_STOP_BIT];
                clr_req <= wdata[CTRL_CLR_BIT];
                sel     <= wdata[SW-1:0];
            end
        end
    end

    // Snapshot: the first high read captures the low byte; a low read releases it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            snap_q <= '0;
        end else if (hi_rd && !held_q) begin
            held_q <= 1'b1;
            snap_q <= count[BW-1:0];
        end else if (lo_rd) begin
            held_q <= 1'b0;
        end
    end

    // Read mux. The clear bit is never returned.
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (addr)
                ADR_CTRL: begin
                    rdata                = '0;
                    rdata[CTRL_STOP_BIT] = stop;
                    rdata[SW-1:0]        = sel;
                end
                ADR_CNT_HI: rdata = count[CW-1:BW];
                ADR_CNT_LO: rdata = held_q ? snap_q : count[BW-1:0];
                default:    rdata = '0;
            endcase
        end
    end

    // R7: the stored byte stays frozen until the low byte is read.
    assert_snap_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !lo_rd) |=> (held_q && $stable(snap_q)));

    // R2: the clear bit always reads as zero.
    assert_clr_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == ADR_CTRL) |-> !rdata[CTRL_CLR_BIT]);

endmodule

// File: rtl/prescaled_timer.sv
// Module: prescaled_timer (top)
// 16-bit timer counter with a selectable prescaler or an external count clock,
// controlled and read over an 8-bit register bus.
// Assumes a single bus clock domain; ext_clk is asynchronous and slower than clk/2.
module prescaled_timer
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             ext_clk
);

    localparam int SYNC_STAGES = 2;

    logic             stop, clr_req, ext_pulse, tick, run;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] count;

    // Counting is allowed whenever the stop bit is clear.
    always_comb begin
        run = ~stop;
    end

    tmr_bus_regs #(.BW(BUS_W), .CW(CNT_W), .SW(SEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .count   (count),
        .rdata   (bus_rdata),
        .stop    (stop),
        .clr_req (clr_req),
        .sel     (sel)
    );

    tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_in     (ext_clk),
        .rise_pulse (ext_pulse)
    );

    tmr_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .clr       (clr_req),
        .sel       (sel),
        .ext_pulse (ext_pulse),
        .tick      (tick)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_req),
        .inc   (tick),
        .value (count)
    );

    // R1: a pending clear always yields a zero count on the next edge.
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (count == '0));

    // R9: a stopped timer with no clear keeps its count.
    assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !clr_req) |=> $stable(count));

    // R3: stop and clear in one write park the count at zero.
    assert_park_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && count == '0 && !bus_wr) |=> (count == '0));

endmodule

// File: tb/tb_prescaled_timer.sv
`timescale 1ns/1ps
module tb_prescaled_timer;

    localparam logic [7:0] STOP = 8'h80;
    localparam logic [7:0] CLR  = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       sample_ev;

    always #2.5 clk = ~clk;

    prescaled_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk(ext_clk)
    );

    // Monitor: pops one expected item per read and compares it with the bus.
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: got %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    // One-cycle register write; the write takes effect on the posedge inside.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    // Driver: one-cycle read that pushes the expected value to the scoreboard.
    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        #1 ->sample_ev;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rd16(input logic [15:0] e, input string t);
        rd(2'd1, e[15:8], t);
        rd(2'd2, e[7:0], t);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Zero and stop with a select, start it, let it run, then stop it.
    // Counts over j+1 edges.
    task automatic run_window(input logic [2:0] s, input int j);
        wr(2'd0, STOP | CLR | {5'd0, s});
        wr(2'd0, {5'd0, s});
        idle(j);
        wr(2'd0, STOP | {5'd0, s});
    endtask

    initial begin
        // R10: reset values, observed while reset is held
        idle(2);
        rd(2'd0, 8'h00, "R10 ctrl");
        rd16(16'h0000, "R10 count");
        rd(2'd3, 8'h00, "R10 spare");
        @(negedge clk); rst_n = 1'b1;

        // R4: each divider ratio
        for (int s = 0; s < 7; s++) begin
            run_window(s[2:0], 150);
            rd16(16'(151 >> s), $sformatf("R4 sel%0d", s));
        end

        // R1: clear while running, then resume from zero
        wr(2'd0, 8'h00);
        idle(20);
        wr(2'd0, CLR);
        idle(10);
        wr(2'd0, STOP);
        rd16(16'd10, "R1 resume");

        // R2: the clear bit reads 0, and the other fields keep the written values
        wr(2'd0, CLR | 8'h05);
        rd(2'd0, 8'h05, "R2 ctrl");
        wr(2'd0, STOP | 8'h05);
        rd(2'd0, 8'h85, "R2 ctrl stop");

        // R3: stop with clear parks the counter at zero
        wr(2'd0, 8'h00);
        idle(50);
        wr(2'd0, STOP | CLR);
        idle(5);
        rd16(16'h0000, "R3 park");
        rd(2'd0, 8'h80, "R3 ctrl");

        // R9: the divider phase survives a stop; reads work while stopped
        wr(2'd0, STOP | CLR | 8'h02);
        wr(2'd0, 8'h02);
        idle(5);
        wr(2'd0, STOP | 8'h02);
        idle(4);
        rd16(16'd1, "R9 stopped");
        wr(2'd0, 8'h02);
        idle(5);
        wr(2'd0, STOP | 8'h02);
        rd16(16'd3, "R9 resumed");

        // R6/R7/R8: coherent reads while the counter runs at full rate
        begin
            int j;
            j = 300;
            wr(2'd0, STOP | CLR);
            wr(2'd0, 8'h00);
            idle(j);
            rd(2'd1, 8'((j) >> 8), "R6 hi");
            rd(2'd2, 8'(j), "R6 lo snapshot");
            rd(2'd1, 8'((j + 2) >> 8), "R7 hi first");
            rd(2'd1, 8'((j + 3) >> 8), "R7 hi again");
            rd(2'd2, 8'(j + 2), "R7 lo kept");
            rd(2'd2, 8'(j + 5), "R8 lo live");
        end

        // R5: external edges, synchronized
        wr(2'd0, STOP | CLR | 8'h07);
        wr(2'd0, 8'h07);
        idle(3);
        for (int p = 0; p < 5; p++) begin
            @(negedge clk); ext_clk = 1'b1;
            idle(4);
            ext_clk = 1'b0;
            idle(4);
        end
        idle(6);
        wr(2'd0, STOP | 8'h07);
        rd16(16'd5, "R5 ext edges");

        // R11: wrap past 0xFFFF
        run_window(3'd0, 65540);
        rd16(16'd5, "R11 wrap");

        done = 1'b1;
        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(5.0 * 190000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule